// File: doc/BRIEF.md
# Bit-Sliced Arithmetic-Logic Unit with Signed Less-Than

A purely combinational arithmetic-logic unit assembled from a row of identical one-bit cells. Each cell holds a full adder, a conditional inverter on its second operand and a small result multiplexer. The cells are chained through their carries, so add and subtract share one ripple path. Subtract inverts the second operand in every cell and forces the chain's carry-in to one.

Signed set-on-less-than uses the subtract path. A small unit beside the top cell forms a "set" bit: the sign of the difference, corrected for signed overflow. That bit is routed back into the spare "less" input of cell 0. The spare inputs of all other cells are tied low, so only bit 0 can be non-zero.

The unit drives a result word and three flags: zero, signed overflow and unsigned carry-out. It has no clock, so operands and operation select go straight through to the outputs within the same cycle. There is no handshake, because no transfer is ever held.

Top module: `slice_alu`

## Requirements
- R1: With select 3'b000 the result is the bitwise AND of the two operands.
- R2: With select 3'b001 the result is the bitwise OR of the two operands.
- R3: With select 3'b010 the result is the sum of the operands modulo 2^W. The carry flag is bit W of the unsigned sum.
- R4: With select 3'b110 the result is A minus B modulo 2^W, formed as A + ~B + 1. The carry flag is the carry out of that sum, which is 1 exactly when A >= B unsigned.
- R5: With select 3'b111 bit 0 of the result is 1 exactly when A < B as signed two's-complement values. This holds even when A - B overflows. All other result bits are 0.
- R6: For the five listed selects, the zero flag is 1 exactly when every result bit is 0.
- R7: The overflow flag is 1 only for selects 3'b010 and 3'b110, and only when the signed result falls outside the range of W bits. For every other select it reads 0.
- R8: The carry flag reads 0 for selects 3'b000, 3'b001 and 3'b111.
- R9: Selects 3'b011, 3'b100 and 3'b101 drive a result of 0 with the zero, overflow and carry flags all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | W (32) | First operand |
| b_i | input | W (32) | Second operand |
| op_i | input | 3 | Operation select |
| result_o | output | W (32) | Result word |
| zero_o | output | 1 | Result is all zeros (legal selects only) |
| overflow_o | output | 1 | Signed overflow of add or subtract |
| carry_o | output | 1 | Carry out of the top cell for add or subtract |

## Verification
The assertions check the following whenever the inputs are known:
- the sum and carry of every add against a wide addition;
- that the set-on-less-than result has its upper bits clear;
- that the flags are gated correctly for the non-arithmetic selects;
- that the three unused selects produce all zeros;
- that the zero flag matches the result.

Only the bench scenarios show three things:
- that the less-than bit stays correct when the subtraction overflows, at the 0x7FFFFFFF / 0x80000000 and 0x80000000 / 1 corners;
- that subtract-borrow and overflow are right for each pattern;
- that a four-bit copy of the unit behaves correctly over every operand pair and select.

// File: rtl/slice_alu_pkg.sv
package slice_alu_pkg;

  typedef enum logic [2:0] {
    OP_AND = 3'b000,
    OP_OR  = 3'b001,
    OP_ADD = 3'b010,
    OP_SUB = 3'b110,
    OP_SLT = 3'b111
  } alu_op_e;

  typedef enum logic [2:0] {
    SEL_AND  = 3'd0,
    SEL_OR   = 3'd1,
    SEL_SUM  = 3'd2,
    SEL_LESS = 3'd3,
    SEL_NONE = 3'd4
  } res_sel_e;

  typedef struct packed {
    logic     invert_b;
    logic     carry_in;
    res_sel_e sel;
    logic     arith;
    logic     legal;
  } alu_ctrl_t;

endpackage

// File: rtl/alu_op_decode.sv
module alu_op_decode
  import slice_alu_pkg::*;
(
  input  logic [2:0] op_i,
  output alu_ctrl_t  ctrl_o
);
  always_comb begin
    ctrl_o          = '0;
    ctrl_o.sel      = SEL_NONE;
    // the upper select bit both inverts B and injects the carry into cell 0
    ctrl_o.invert_b = op_i[2];
    ctrl_o.carry_in = op_i[2];
    case (op_i)
      OP_AND: begin ctrl_o.sel = SEL_AND;  ctrl_o.legal = 1'b1; end
      OP_OR:  begin ctrl_o.sel = SEL_OR;   ctrl_o.legal = 1'b1; end
      OP_ADD: begin ctrl_o.sel = SEL_SUM;  ctrl_o.legal = 1'b1; ctrl_o.arith = 1'b1; end
      OP_SUB: begin ctrl_o.sel = SEL_SUM;  ctrl_o.legal = 1'b1; ctrl_o.arith = 1'b1; end
      OP_SLT: begin ctrl_o.sel = SEL_LESS; ctrl_o.legal = 1'b1; end
      default: begin
        ctrl_o.invert_b = 1'b0;
        ctrl_o.carry_in = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
  import slice_alu_pkg::*;
(
  input  logic     a_i,
  input  logic     b_i,
  input  logic     invert_b_i,
  input  logic     carry_i,
  input  logic     less_i,
  input  res_sel_e sel_i,
  output logic     res_o,
  output logic     carry_o
);
  logic b_eff;
  logic sum;

  assign b_eff   = b_i ^ invert_b_i;
  assign sum     = a_i ^ b_eff ^ carry_i;
  assign carry_o = (a_i & b_eff) | (a_i & carry_i) | (b_eff & carry_i);

  always_comb begin
    case (sel_i)
      SEL_AND:  res_o = a_i & b_i;
      SEL_OR:   res_o = a_i | b_i;
      SEL_SUM:  res_o = sum;
      SEL_LESS: res_o = less_i;
      default:  res_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_set_unit.sv
module alu_set_unit (
  input  logic a_msb_i,
  input  logic b_msb_i,
  input  logic invert_b_i,
  input  logic carry_into_msb_i,
  input  logic carry_out_msb_i,
  output logic set_o,
  output logic ovf_o
);
  logic diff_sign;

  assign diff_sign = a_msb_i ^ b_msb_i ^ invert_b_i ^ carry_into_msb_i;
  assign ovf_o     = carry_into_msb_i ^ carry_out_msb_i;
  // overflow flips the apparent sign of the difference
  assign set_o     = diff_sign ^ ovf_o;
endmodule

// File: rtl/alu_flags.sv
module alu_flags #(
  parameter int W = 32
) (
  input  logic [W-1:0] result_i,
  input  logic         carry_top_i,
  input  logic         ovf_raw_i,
  input  logic         arith_i,
  input  logic         legal_i,
  output logic         zero_o,
  output logic         overflow_o,
  output logic         carry_o
);
  assign zero_o     = legal_i & ~(|result_i);
  assign overflow_o = arith_i & ovf_raw_i;
  assign carry_o    = arith_i & carry_top_i;
endmodule

// File: rtl/slice_alu.sv
module slice_alu
  import slice_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [2:0]   op_i,
  output logic [W-1:0] result_o,
  output logic         zero_o,
  output logic         overflow_o,
  output logic         carry_o
);
  localparam int MSB = W - 1;

  alu_ctrl_t    ctrl;
  logic [W:0]   chain;
  logic [W-1:0] less_v;
  logic         set_bit;
  logic         ovf_raw;

  alu_op_decode u_dec (.op_i(op_i), .ctrl_o(ctrl));

  assign chain[0] = ctrl.carry_in;

  for (genvar i = 0; i < W; i++) begin : g_cell
    if (i == 0) begin : g_lsb
      assign less_v[i] = set_bit;
    end else begin : g_upper
      assign less_v[i] = 1'b0;
    end
    alu_bit_slice u_slice (
      .a_i       (a_i[i]),
      .b_i       (b_i[i]),
      .invert_b_i(ctrl.invert_b),
      .carry_i   (chain[i]),
      .less_i    (less_v[i]),
      .sel_i     (ctrl.sel),
      .res_o     (result_o[i]),
      .carry_o   (chain[i+1])
    );
  end

  alu_set_unit u_set (
    .a_msb_i         (a_i[MSB]),
    .b_msb_i         (b_i[MSB]),
    .invert_b_i      (ctrl.invert_b),
    .carry_into_msb_i(chain[MSB]),
    .carry_out_msb_i (chain[W]),
    .set_o           (set_bit),
    .ovf_o           (ovf_raw)
  );

  alu_flags #(.W(W)) u_flags (
    .result_i   (result_o),
    .carry_top_i(chain[W]),
    .ovf_raw_i  (ovf_raw),
    .arith_i    (ctrl.arith),
    .legal_i    (ctrl.legal),
    .zero_o     (zero_o),
    .overflow_o (overflow_o),
    .carry_o    (carry_o)
  );
endmodule

// File: rtl/slice_alu_chk.sv
module slice_alu_chk #(
  parameter int W = 32
) (
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [2:0]   op_i,
  input logic [W-1:0] result_o,
  input logic         zero_o,
  input logic         overflow_o,
  input logic         carry_o
);
  logic [W:0] wide_sum;
  logic       known;

  assign wide_sum = {1'b0, a_i} + {1'b0, b_i};
  assign known    = !$isunknown({a_i, b_i, op_i});

  always_comb begin
    if (known) begin
      if (op_i == 3'b010) AST_ADD_SUM: assert ({carry_o, result_o} == wide_sum); // R3
      if (op_i == 3'b111) AST_SLT_UPPER_ZERO: assert (result_o[W-1:1] == '0); // R5
      if (op_i == 3'b000 || op_i == 3'b001 || op_i == 3'b111 ||
          op_i == 3'b011 || op_i == 3'b100 || op_i == 3'b101)
        AST_NO_OVERFLOW: assert (!overflow_o); // R7
      if (op_i == 3'b000 || op_i == 3'b001 || op_i == 3'b111)
        AST_NO_CARRY: assert (!carry_o); // R8
      if (op_i == 3'b011 || op_i == 3'b100 || op_i == 3'b101)
        AST_UNUSED_QUIET: assert (result_o == '0 && !zero_o && !carry_o); // R9
      else
        AST_ZERO_MATCH: assert (zero_o == (result_o == '0)); // R6
    end
  end
endmodule

bind slice_alu slice_alu_chk #(.W(W)) u_chk (
  .a_i       (a_i),
  .b_i       (b_i),
  .op_i      (op_i),
  .result_o  (result_o),
  .zero_o    (zero_o),
  .overflow_o(overflow_o),
  .carry_o   (carry_o)
);

// File: tb/slice_alu_tb.sv
`timescale 1ns/1ps
module slice_alu_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  int total = 0;
  int bad   = 0;

  logic [31:0] a32, b32, r32;
  logic [2:0]  op32;
  logic        z32, v32, c32;
  logic [3:0]  a4, b4, r4;
  logic [2:0]  op4;
  logic        z4, v4, c4;

  slice_alu #(.W(32)) u_dut (.a_i(a32), .b_i(b32), .op_i(op32), .result_o(r32),
                             .zero_o(z32), .overflow_o(v32), .carry_o(c32));
  slice_alu #(.W(4)) u_small (.a_i(a4), .b_i(b4), .op_i(op4), .result_o(r4),
                              .zero_o(z4), .overflow_o(v4), .carry_o(c4));

  function automatic string res_tag(input logic [2:0] op);
    case (op)
      3'b000: return "R1";
      3'b001: return "R2";
      3'b010: return "R3";
      3'b110: return "R4";
      3'b111: return "R5";
      default: return "R9";
    endcase
  endfunction

  function automatic bit legal(input logic [2:0] op);
    return op == 3'b000 || op == 3'b001 || op == 3'b010 || op == 3'b110 || op == 3'b111;
  endfunction

  // arithmetic reference model for width w
  task automatic model(input int w, input logic [2:0] op, input longint unsigned a,
                       input longint unsigned b, output longint unsigned r,
                       output bit z, output bit v, output bit c);
    longint unsigned mask = (64'd1 << w) - 1;
    longint sa, sb, sr, lo, hi;
    longint unsigned full;
    sa = ((a >> (w-1)) & 1) ? longint'(a) - longint'(64'd1 << w) : longint'(a);
    sb = ((b >> (w-1)) & 1) ? longint'(b) - longint'(64'd1 << w) : longint'(b);
    lo = -longint'(64'd1 << (w-1));
    hi = longint'(64'd1 << (w-1)) - 1;
    r = 0; v = 0; c = 0;
    case (op)
      3'b000: r = a & b;
      3'b001: r = a | b;
      3'b010: begin
        full = a + b; r = full & mask; c = bit'((full >> w) & 1);
        sr = sa + sb; v = (sr < lo) || (sr > hi);
      end
      3'b110: begin
        full = a + ((~b) & mask) + 1; r = full & mask; c = bit'((full >> w) & 1);
        sr = sa - sb; v = (sr < lo) || (sr > hi);
      end
      3'b111: r = (sa < sb) ? 1 : 0;
      default: r = 0;
    endcase
    z = legal(op) && (r == 0);
  endtask

  task automatic check(input string tag, input string what,
                       input longint unsigned act, input longint unsigned exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input logic [2:0] op, input longint unsigned ar,
                         input bit az, input bit av, input bit ac,
                         input longint unsigned er, input bit ez, input bit ev, input bit ec);
    string t = res_tag(op);
    check(t, "result", ar, er);
    check(legal(op) ? "R6" : "R9", "zero", az, ez);
    check(legal(op) ? "R7" : "R9", "overflow", av, ev);
    check((op == 3'b010 || op == 3'b110) ? t : (legal(op) ? "R8" : "R9"), "carry", ac, ec);
  endtask

  task automatic run32(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
    longint unsigned er; bit ez, ev, ec;
    @(negedge clk);
    op32 = op; a32 = a; b32 = b;
    #1;
    model(32, op, a, b, er, ez, ev, ec);
    compare(op, r32, z32, v32, c32, er, ez, ev, ec);
  endtask

  task automatic run4(input logic [2:0] op, input logic [3:0] a, input logic [3:0] b);
    longint unsigned er; bit ez, ev, ec;
    @(negedge clk);
    op4 = op; a4 = a; b4 = b;
    #1;
    model(4, op, a, b, er, ez, ev, ec);
    compare(op, r4, z4, v4, c4, er, ez, ev, ec);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #400000;
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    a32 = '0; b32 = '0; op32 = 3'b000;
    a4 = '0; b4 = '0; op4 = 3'b000;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // idle state: AND of zeros gives zero result and raised zero flag (R6)
    @(negedge clk); #1;
    check("R6", "idle zero", z32, 1);
    check("R1", "idle result", r32, 0);
    // corner operand pairs, every select (R5 overflow cases among them)
    for (int op = 0; op < 8; op++) begin
      run32(3'(op), 32'h7FFF_FFFF, 32'h8000_0000);
      run32(3'(op), 32'h8000_0000, 32'h7FFF_FFFF);
      run32(3'(op), 32'h8000_0000, 32'h0000_0001);
      run32(3'(op), 32'h0000_0001, 32'h8000_0000);
      run32(3'(op), 32'h1234_5678, 32'h1234_5678);
      run32(3'(op), 32'hFFFF_FFFF, 32'h0000_0001);
      run32(3'(op), 32'h0000_0000, 32'hFFFF_FFFF);
      run32(3'(op), 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    end
    // random operands, every select (R1..R9)
    for (int n = 0; n < 300; n++) begin
      for (int op = 0; op < 8; op++) run32(3'(op), $urandom, $urandom);
    end
    // exhaustive sweep of the four-bit copy (R1..R9)
    for (int op = 0; op < 8; op++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          run4(3'(op), 4'(a), 4'(b));
    finish_run();
  end
endmodule